// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the twelve-slot machine cycle of an 8051-style core and drives the multiplexed external memory bus from it. Each machine cycle has six states, each split into two phases. The slot counter runs from 0 to 11. Slot k is state k/2+1, phase k%2+1, so slot 1 is S1P2 and slot 9 is S5P2. The counter is exported so the rest of the core can align to it.

At the last slot of every cycle the block samples the core-side request: the program counter, the external-access strap, and an optional external data transfer. That sample defines the next cycle.
- A fetch cycle performs two code-byte fetches, at PC and PC+1. Each fetch is external or internal depending on the strap and on an internal ROM limit.
- A data cycle performs one external read or write with a 16-bit or an 8-bit address. It skips both code fetches and the second address strobe.

On the pin side the block drives the address latch strobe, the code read strobe, and the data read and write strobes. It also drives a port 0 byte with an output enable, which carries the low address and then the data, and a port 2 byte. The port 0 and port 2 output latches live here, because external accesses interact with them.

Top module: `ext_bus_seq`

## Requirements
- R1: `slot_o` counts 0,1,...,11 and wraps to 0. It is 0 during reset and advances once per clock.
- R2: After reset:
  - both latch outputs read FFh;
  - the first machine cycle is idle: the address strobe stays low, all three read/write strobes stay high, port 0 is not driven, and port 2 shows its latch.
- R3: The address strobe `ale_o` is high in slots 1, 2, 7 and 8 of a fetch cycle, for internal and external fetches alike. In a data cycle it is high only in slots 1 and 2.
- R4: An external fetch has two parts:
  - Port 0 drives the low byte of the fetch address in slots 0–2 (first fetch) or 6–8 (second fetch).
  - `psen_no` is low in slots 3–4 or 9–10. The byte on `p0_di_i` is sampled at the end of slot 4 or 10 and is presented on `code_o` with `code_vld_o` high during slot 5 or 11.
  - The second fetch address is PC+1, modulo 2^16.
- R5: `pc_i` and `ea_i` are sampled at the end of slot 11. A fetch is external when `ea_i` is 0, or when its address is greater than ROM_LIMIT (default 1FFFh). The choice is made separately for each of the two fetches.
- R6: During an internal fetch `psen_no` stays high, `p0_oe_o` is 0, `p2_o` shows the port 2 latch, and `code_vld_o` stays low.
- R7: During an external fetch `p2_o` carries the high byte of that fetch's address for its half cycle (slots 0–5 or 6–11). During a 16-bit data cycle `p2_o` carries the high address byte for all 12 slots.
- R8: During an 8-bit data cycle `p2_o` shows the port 2 latch for all 12 slots, and the upper address byte is ignored.
- R9: If `xreq_i` is high at the end of slot 11, the next cycle is a data cycle. `xwe_i` = 1 selects a write, and `xwide_i` = 1 selects 16-bit addressing. In a data cycle, port 0 drives the low address byte in slots 0–2 and `psen_no` stays high.
- R10: In a write cycle `wr_no` is low in slots 4–9. Port 0 drives `xwdata_i` in slots 3–10.
- R11: In a read cycle `rd_no` is low in slots 4–9 and port 0 is released in slots 3–11. `p0_di_i` is sampled at the end of slot 9 and presented on `xrdata_o` with `xrd_vld_o` high during slot 10.
- R12: At most one of `psen_no`, `rd_no` and `wr_no` is low in any slot.
- R13: The port latches behave as follows:
  - `p0_wr_i` and `p2_wr_i` load `sfr_wdata_i` into the port 0 and port 2 latches.
  - Every external access sets the port 0 latch to FFh at the end of its last address slot.
  - External accesses never change the port 2 latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, one slot per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Program counter for the next fetch cycle |
| ea_i | input | 1 | External-access strap, 0 forces external code |
| xreq_i | input | 1 | Request a data cycle next |
| xwe_i | input | 1 | Data cycle is a write |
| xwide_i | input | 1 | Data cycle uses a 16-bit address |
| xaddr_i | input | 16 | Data address |
| xwdata_i | input | 8 | Write data |
| p0_wr_i | input | 1 | Load port 0 latch |
| p2_wr_i | input | 1 | Load port 2 latch |
| sfr_wdata_i | input | 8 | Latch write data |
| p0_di_i | input | 8 | Port 0 pin input |
| code_o | output | 8 | Fetched code byte |
| code_vld_o | output | 1 | `code_o` valid |
| xrdata_o | output | 8 | External read data |
| xrd_vld_o | output | 1 | `xrdata_o` valid |
| slot_o | output | 4 | Current phase slot 0..11 |
| ale_o | output | 1 | Address latch strobe |
| psen_no | output | 1 | Code read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| p0_do_o | output | 8 | Port 0 output byte |
| p0_oe_o | output | 1 | Port 0 output enable |
| p2_o | output | 8 | Port 2 output byte |
| p0_latch_o | output | 8 | Port 0 latch value |
| p2_latch_o | output | 8 | Port 2 latch value |

## Verification
The bench targets a PC of 1FFFh with the strap high. There the first fetch is internal and the second is external. A design that makes the internal/external choice once per cycle would either strobe the code read for an internal address or miss the byte at 2000h.

Data cycles are run in both address modes against a latch-and-memory model. The bench writes through an 8-bit address and reads the same location back through a 16-bit address. A design that put the upper address byte on port 2 in 8-bit mode would land the write at the wrong location.

Strobe and enable masks are compared slot by slot. This catches:
- an address strobe left in the second half of a data cycle;
- write data released before the write strobe rises;
- a port 0 latch that is not set to FFh after an external access, or one that is set to FFh after an internal-only cycle.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  localparam int SLOTS = 12;
  localparam int HALF  = 6;
  localparam int SW    = $clog2(SLOTS);

  // positions inside a half cycle
  localparam int ALE_A  = 1;
  localparam int ALE_B  = 2;
  localparam int FS_A   = 3;
  localparam int FS_B   = 4;
  // positions inside a data cycle
  localparam int XS_A   = 4;
  localparam int XS_B   = 9;
  localparam int WD_A   = 3;
  localparam int WD_B   = 10;

  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,
    CK_FETCH = 2'd1,
    CK_XRD   = 2'd2,
    CK_XWR   = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/ebs_slot_ctr.sv
module ebs_slot_ctr #(
  parameter int N  = 12,
  parameter int SW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] slot_o,
  output logic          last_o
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;
  assign last_o = (slot_q == LAST);

  a_r1_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST);
  a_r1_slot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q == LAST |=> slot_q == '0);
endmodule

// File: rtl/ebs_code_sel.sv
module ebs_code_sel #(
  parameter int AW        = 16,
  parameter int NF        = 2,
  parameter int ROM_LIMIT = 16'h1FFF
) (
  input  logic [AW-1:0] pc_i,
  input  logic          ea_i,
  output logic [NF-1:0] ext_o
);
  localparam logic [AW-1:0] LIM = AW'(ROM_LIMIT);

  for (genvar i = 0; i < NF; i++) begin : g_fetch
    logic [AW-1:0] addr;
    assign addr     = pc_i + AW'(i);
    assign ext_o[i] = !ea_i || (addr > LIM);
  end
endmodule

// File: rtl/ebs_port_latch.sv
module ebs_port_latch #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          force_ff_i,
  input  logic          p0_wr_i,
  input  logic          p2_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] p0_q_o,
  output logic [DW-1:0] p2_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_q_o <= '1;
      p2_q_o <= '1;
    end else begin
      if (force_ff_i)   p0_q_o <= '1;
      else if (p0_wr_i) p0_q_o <= wdata_i;
      if (p2_wr_i)      p2_q_o <= wdata_i;
    end
  end

  a_r13_p0_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ff_i |=> p0_q_o == '1);
  a_r13_p2_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p2_wr_i |=> $stable(p2_q_o));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ROM_LIMIT = 16'h1FFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic          ea_i,
  input  logic          xreq_i,
  input  logic          xwe_i,
  input  logic          xwide_i,
  input  logic [AW-1:0] xaddr_i,
  input  logic [DW-1:0] xwdata_i,
  input  logic          p0_wr_i,
  input  logic          p2_wr_i,
  input  logic [DW-1:0] sfr_wdata_i,
  input  logic [DW-1:0] p0_di_i,
  output logic [DW-1:0] code_o,
  output logic          code_vld_o,
  output logic [DW-1:0] xrdata_o,
  output logic          xrd_vld_o,
  output logic [SW-1:0] slot_o,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic [DW-1:0] p0_do_o,
  output logic          p0_oe_o,
  output logic [DW-1:0] p2_o,
  output logic [DW-1:0] p0_latch_o,
  output logic [DW-1:0] p2_latch_o
);
  localparam int NF = 2;
  localparam int HB = AW - DW;

  logic          last;
  logic [NF-1:0] ext_nx;
  logic          force_ff;

  ebs_slot_ctr #(.N(SLOTS), .SW(SW)) u_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_o(slot_o),
    .last_o(last)
  );

  ebs_code_sel #(.AW(AW), .NF(NF), .ROM_LIMIT(ROM_LIMIT)) u_sel (
    .pc_i (pc_i),
    .ea_i (ea_i),
    .ext_o(ext_nx)
  );

  ebs_port_latch #(.DW(DW)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .force_ff_i(force_ff),
    .p0_wr_i   (p0_wr_i),
    .p2_wr_i   (p2_wr_i),
    .wdata_i   (sfr_wdata_i),
    .p0_q_o    (p0_latch_o),
    .p2_q_o    (p2_latch_o)
  );

  // cycle descriptor, loaded at the end of the last slot
  cyc_kind_e     kind_q;
  logic [AW-1:0] pc_q;
  logic [NF-1:0] ext_q;
  logic [AW-1:0] xa_q;
  logic [DW-1:0] xd_q;
  logic          xw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= CK_IDLE;
      pc_q   <= '0;
      ext_q  <= '0;
      xa_q   <= '0;
      xd_q   <= '0;
      xw_q   <= 1'b0;
    end else if (last) begin
      kind_q <= xreq_i ? (xwe_i ? CK_XWR : CK_XRD) : CK_FETCH;
      pc_q   <= pc_i;
      ext_q  <= ext_nx;
      xa_q   <= xaddr_i;
      xd_q   <= xwdata_i;
      xw_q   <= xwide_i;
    end
  end

  logic          half;
  logic [SW-1:0] sl;
  logic          is_f, is_x, ext_f;
  logic [AW-1:0] f_addr;

  always_comb begin
    half   = (slot_o >= SW'(HALF));
    sl     = half ? slot_o - SW'(HALF) : slot_o;
    is_f   = (kind_q == CK_FETCH);
    is_x   = (kind_q == CK_XRD) || (kind_q == CK_XWR);
    ext_f  = is_f && ext_q[half];
    f_addr = pc_q + AW'(half);
  end

  always_comb begin
    ale_o   = (is_f || (is_x && !half)) && (sl == SW'(ALE_A) || sl == SW'(ALE_B));
    psen_no = !(ext_f && (sl == SW'(FS_A) || sl == SW'(FS_B)));
    rd_no   = !(kind_q == CK_XRD && slot_o >= SW'(XS_A) && slot_o <= SW'(XS_B));
    wr_no   = !(kind_q == CK_XWR && slot_o >= SW'(XS_A) && slot_o <= SW'(XS_B));

    p0_oe_o = 1'b0;
    p0_do_o = p0_latch_o;
    if (ext_f && sl <= SW'(ALE_B)) begin
      p0_oe_o = 1'b1;
      p0_do_o = f_addr[DW-1:0];
    end else if (is_x && slot_o <= SW'(ALE_B)) begin
      p0_oe_o = 1'b1;
      p0_do_o = xa_q[DW-1:0];
    end else if (kind_q == CK_XWR && slot_o >= SW'(WD_A) && slot_o <= SW'(WD_B)) begin
      p0_oe_o = 1'b1;
      p0_do_o = xd_q;
    end

    if (ext_f)              p2_o = f_addr[AW-1:AW-HB];
    else if (is_x && xw_q)  p2_o = xa_q[AW-1:AW-HB];
    else                    p2_o = p2_latch_o;

    force_ff = (sl == SW'(ALE_B)) && (ext_f || (is_x && !half));
  end

  // return path sampling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o     <= '0;
      code_vld_o <= 1'b0;
      xrdata_o   <= '0;
      xrd_vld_o  <= 1'b0;
    end else begin
      code_vld_o <= ext_f && (sl == SW'(FS_B));
      if (ext_f && sl == SW'(FS_B)) code_o <= p0_di_i;
      xrd_vld_o  <= (kind_q == CK_XRD) && (slot_o == SW'(XS_B));
      if (kind_q == CK_XRD && slot_o == SW'(XS_B)) xrdata_o <= p0_di_i;
    end
  end

  a_r12_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!psen_no, !rd_no, !wr_no}) <= 1);
  a_r4_psen_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> !p0_oe_o);
  a_r4_code_after_psen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld_o |-> $past(!psen_no));
  a_r11_rd_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !p0_oe_o);
  a_r11_rdata_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xrd_vld_o |-> $past(!rd_no));
  a_r10_wr_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> p0_oe_o);
  a_r10_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> p0_oe_o);
endmodule

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc = '0;
  logic        ea = 1'b0;
  logic        xreq = 1'b0, xwe = 1'b0, xwide = 1'b0;
  logic [15:0] xaddr = '0;
  logic [7:0]  xwdata = '0;
  logic        p0w = 1'b0, p2w = 1'b0;
  logic [7:0]  sfrd = '0;
  logic [7:0]  p0_di;
  logic [7:0]  code, xrdata, p0_do, p2, p0_lat, p2_lat;
  logic        code_vld, xrd_vld, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [3:0]  slot;

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ext_bus_seq u_ext_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .ea_i(ea), .xreq_i(xreq),
    .xwe_i(xwe), .xwide_i(xwide), .xaddr_i(xaddr), .xwdata_i(xwdata),
    .p0_wr_i(p0w), .p2_wr_i(p2w), .sfr_wdata_i(sfrd), .p0_di_i(p0_di),
    .code_o(code), .code_vld_o(code_vld), .xrdata_o(xrdata), .xrd_vld_o(xrd_vld),
    .slot_o(slot), .ale_o(ale), .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n),
    .p0_do_o(p0_do), .p0_oe_o(p0_oe), .p2_o(p2),
    .p0_latch_o(p0_lat), .p2_latch_o(p2_lat)
  );

  // external address latch and memories
  logic [7:0] xmem [0:1023];
  logic [7:0] ext_lat = '0;
  logic       ale_d = 1'b0, wr_d = 1'b1;
  logic [7:0] p0_d = '0, p2_d = '0;

  function automatic logic [7:0] cb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_comb begin
    if (!psen_n)    p0_di = cb({p2, ext_lat});
    else if (!rd_n) p0_di = xmem[{p2[1:0], ext_lat}];
    else            p0_di = 8'h00;
  end

  always @(negedge clk) begin
    if (ale_d && !ale) ext_lat <= p0_d;
    if (!wr_d && wr_n) xmem[{p2_d[1:0], ext_lat}] <= p0_d;
    ale_d <= ale; wr_d <= wr_n; p0_d <= p0_do; p2_d <= p2;
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired: got %0d cycles, expected < 20000", ncyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // per-cycle recording
  logic [11:0] m_ale, m_psen, m_rd, m_wr, m_oe;
  logic [7:0]  p2_rec [12];
  logic [7:0]  codes [4];
  int          n_code, n_rd, slot_bad, excl_bad;
  logic [7:0]  rd_val;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic record_cyc();
    m_ale = '0; m_psen = '0; m_rd = '0; m_wr = '0; m_oe = '0;
    n_code = 0; n_rd = 0; slot_bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      p0w = 1'b0; p2w = 1'b0; xreq = 1'b0;
      if (slot != 4'(i)) slot_bad++;
      m_ale[i] = ale; m_psen[i] = !psen_n; m_rd[i] = !rd_n;
      m_wr[i] = !wr_n; m_oe[i] = p0_oe; p2_rec[i] = p2;
      if ((!psen_n + !rd_n + !wr_n) > 1) excl_bad++;
      if (code_vld && n_code < 4) begin codes[n_code] = code; n_code++; end
      if (xrd_vld) begin rd_val = xrdata; n_rd++; end
    end
  endtask

  // called at a slot-11 negedge; records the cycle the inputs define
  task automatic run_cyc(input logic [15:0] p, input logic e, input logic rq,
                         input logic we, input logic wd, input logic [15:0] a,
                         input logic [7:0] d);
    pc = p; ea = e; xreq = rq; xwe = we; xwide = wd; xaddr = a; xwdata = d;
    record_cyc();
  endtask

  task automatic chk_p2(input string req, input int lo, input int hi, input logic [7:0] exp);
    int bad = 0;
    for (int i = lo; i <= hi; i++) if (p2_rec[i] !== exp) bad++;
    chk(req, 16'(bad), 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) xmem[i] = 8'h00;
    excl_bad = 0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 reset p0 latch", {8'h0, p0_lat}, 16'h00FF);
    chk("R2 reset p2 latch", {8'h0, p2_lat}, 16'h00FF);
    chk("R1 reset slot", {12'h0, slot}, 16'h0000);
    chk("R2 reset strobes", {12'h0, ale, psen_n, rd_n, wr_n}, 16'h0007);
    rst_n = 1'b1;
    // R2 first cycle idle
    begin
      int act = 0;
      do begin
        @(negedge clk);
        if (ale || !psen_n || !rd_n || !wr_n || p0_oe || p2 !== 8'hFF) act++;
      end while (slot != 4'd11);
      chk("R2 idle first cycle", 16'(act), 16'd0);
    end

    // all external, strap low
    run_cyc(16'h0100, 1'b0, 0, 0, 0, 16'h0, 8'h0);
    chk("R1 slot sequence", 16'(slot_bad), 16'd0);
    chk("R3 ale fetch cycle", {4'h0, m_ale}, 16'h0186);
    chk("R4 psen ext both", {4'h0, m_psen}, 16'h0618);
    chk("R4 p0 oe ext both", {4'h0, m_oe}, 16'h01C7);
    chk("R4 code count", 16'(n_code), 16'd2);
    chk("R4 code pc", {8'h0, codes[0]}, {8'h0, cb(16'h0100)});
    chk("R4 code pc+1", {8'h0, codes[1]}, {8'h0, cb(16'h0101)});
    chk_p2("R7 p2 fetch high byte", 0, 11, 8'h01);
    chk("R13 p0 latch ff after ext", {8'h0, p0_lat}, 16'h00FF);

    // load latches, then internal cycle
    p0w = 1'b1; p2w = 1'b0; sfrd = 8'h3C;
    run_cyc(16'h0300, 1'b0, 0, 0, 0, 16'h0, 8'h0);
    p2w = 1'b1; sfrd = 8'h02;
    run_cyc(16'h0200, 1'b1, 0, 0, 0, 16'h0, 8'h0);
    chk("R13 p2 latch write", {8'h0, p2_lat}, 16'h0002);
    run_cyc(16'h0200, 1'b1, 0, 0, 0, 16'h0, 8'h0);
    chk("R3 ale internal cycle", {4'h0, m_ale}, 16'h0186);
    chk("R6 no psen internal", {4'h0, m_psen}, 16'h0000);
    chk("R6 no p0 drive internal", {4'h0, m_oe}, 16'h0000);
    chk("R6 no code internal", 16'(n_code), 16'd0);
    chk_p2("R6 p2 latch internal", 0, 11, 8'h02);
    p0w = 1'b1; sfrd = 8'h3C;
    run_cyc(16'h0200, 1'b1, 0, 0, 0, 16'h0, 8'h0);
    chk("R13 p0 latch kept internal", {8'h0, p0_lat}, 16'h003C);

    // straddle of ROM limit
    run_cyc(16'h1FFF, 1'b1, 0, 0, 0, 16'h0, 8'h0);
    chk("R5 psen only second fetch", {4'h0, m_psen}, 16'h0600);
    chk("R5 oe only second fetch", {4'h0, m_oe}, 16'h01C0);
    chk("R5 code 2000h", {8'h0, codes[0]}, {8'h0, cb(16'h2000)});
    chk("R5 one code", 16'(n_code), 16'd1);
    chk_p2("R6 p2 latch first half", 0, 5, 8'h02);
    chk_p2("R7 p2 high second half", 6, 11, 8'h20);
    chk("R13 p0 latch ff", {8'h0, p0_lat}, 16'h00FF);
    chk("R13 p2 latch kept", {8'h0, p2_lat}, 16'h0002);

    // above limit with strap high
    run_cyc(16'h2100, 1'b1, 0, 0, 0, 16'h0, 8'h0);
    chk("R5 above limit external", {4'h0, m_psen}, 16'h0618);
    chk("R5 code 2101h", {8'h0, codes[1]}, {8'h0, cb(16'h2101)});

    // wide write
    run_cyc(16'h0200, 1'b1, 1, 1, 1, 16'h0155, 8'hA7);
    chk("R3 ale data cycle", {4'h0, m_ale}, 16'h0006);
    chk("R9 no psen data cycle", {4'h0, m_psen}, 16'h0000);
    chk("R10 wr window", {4'h0, m_wr}, 16'h03F0);
    chk("R10 p0 oe write", {4'h0, m_oe}, 16'h07FF);
    chk_p2("R7 p2 wide whole cycle", 0, 11, 8'h01);
    // narrow write
    run_cyc(16'h0200, 1'b1, 1, 1, 0, 16'hFF66, 8'h5B);
    chk_p2("R8 p2 latch narrow", 0, 11, 8'h02);
    chk("R10 wr window narrow", {4'h0, m_wr}, 16'h03F0);
    // wide read
    run_cyc(16'h0200, 1'b1, 1, 0, 1, 16'h0155, 8'h00);
    chk("R11 rd window", {4'h0, m_rd}, 16'h03F0);
    chk("R11 p0 oe read", {4'h0, m_oe}, 16'h0007);
    chk("R11 read count", 16'(n_rd), 16'd1);
    chk("R11 wide read data", {8'h0, rd_val}, 16'h00A7);
    // narrow read
    run_cyc(16'h0200, 1'b1, 1, 0, 0, 16'hAB66, 8'h00);
    chk("R8 narrow read data", {8'h0, rd_val}, 16'h005B);
    chk_p2("R8 p2 latch narrow read", 0, 11, 8'h02);
    // same location through wide address
    run_cyc(16'h0200, 1'b1, 1, 0, 1, 16'h0266, 8'h00);
    chk("R9 wide alias read", {8'h0, rd_val}, 16'h005B);
    chk("R13 p0 latch ff after data", {8'h0, p0_lat}, 16'h00FF);
    // back to internal code: latch reappears
    run_cyc(16'h0040, 1'b1, 0, 0, 0, 16'h0, 8'h0);
    chk_p2("R13 p2 latch reappears", 0, 11, 8'h02);

    chk("R12 strobe exclusivity", 16'(excl_bad), 16'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule